// File: doc/BRIEF.md
# Interrupt Response Bus-Cycle Sequencer

This block runs the bus activity that follows an accepted interrupt on an 8-bit CPU with a 16-bit address bus. One clock equals one T-state. After a one-clock accept pulse, the block runs a fixed series of machine cycles. The series depends on the interrupt kind: a non-maskable request, a maskable request in vectored-restart mode (mode 1), or a maskable request in table-indirect mode (mode 2). During this series the block drives the address bus, the write-data bus, the read, write and acknowledge strobes, and a cycle-type code that changes on every T-state.

The core supplies the program counter, stack pointer and interrupt page register at accept time. During the acknowledge cycle the interrupting device places a response byte on the data bus. At the end of the series the block reports the handler address and the stack pointer after the push, and it pulses done. The core then loads these values into its registers. The block does not carry out an instruction supplied by the device (mode 0). It reports that request as unsupported and performs no bus activity for it.

Top module: `intr_resp_seq`

## Requirements
- R1: While reset is held, and on every idle clock after it, the cycle code is 0 (idle), address and write data are 0, all three strobes are low and done is low.
- R2: A non-maskable accept produces 5 T-states of cycle code 1 (NMI acknowledge) with the address bus showing the captured PC. Two 3-T-state memory writes follow. The handler address reported at done is 0x0066.
- R3: Each write cycle has cycle code 3. The first write puts PC[15:8] at SP-1 and the second puts PC[7:0] at SP-2, modulo 2^16. The stack pointer reported at done is SP-2, modulo 2^16.
- R4: A maskable accept with mode 1 produces 7 T-states of cycle code 2 (interrupt acknowledge), followed by the two writes. The handler address is 0x0038 whatever byte the device supplies.
- R5: A maskable accept with mode 2 produces the 7-T-state acknowledge and the two writes, then two 3-T-state reads with cycle code 4. The first read is at {I, ack byte} and the second at {I, ack byte}+1, modulo 2^16. Bit 0 of the ack byte is kept as read. The handler address is {second read byte, first read byte}.
- R6: The acknowledge strobe is high only in cycle codes 1 and 2. The read strobe is high only in code 4 and the write strobe only in code 3. At most one strobe is high at a time. The write data bus is 0 outside write cycles.
- R7: Done is high for exactly one clock, on the clock after the last T-state. The handler address and stack pointer outputs hold their values until the next done.
- R8: An accept pulse that arrives while a sequence is running, including during its last T-state, has no effect on that sequence and does not start another one.
- R9: A maskable accept with mode 0 or 3 produces a one-clock unsupported pulse on the following clock. It causes no bus cycle and no done pulse, and it leaves the result outputs unchanged.
- R10: When the non-maskable flag is set, the mode input is ignored and the NMI sequence of R2 runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_i | input | 1 | One-clock pulse: an interrupt has been accepted |
| is_nmi_i | input | 1 | Accepted interrupt is non-maskable |
| mode_i | input | 2 | Maskable interrupt mode (1 or 2 supported) |
| pc_i | input | 16 | Program counter to push |
| sp_i | input | 16 | Stack pointer before the push |
| ireg_i | input | 8 | Interrupt page register (upper pointer byte) |
| data_i | input | 8 | Data bus in (ack byte, table reads) |
| addr_o | output | 16 | Address bus |
| dout_o | output | 8 | Write data bus |
| rd_o | output | 1 | Memory read strobe |
| wr_o | output | 1 | Memory write strobe |
| ack_o | output | 1 | Interrupt acknowledge strobe |
| cyc_o | output | 3 | Cycle code of the current T-state |
| done_o | output | 1 | One-clock completion pulse |
| unsup_o | output | 1 | One-clock pulse for an unsupported mode |
| pc_new_o | output | 16 | Handler address |
| sp_new_o | output | 16 | Stack pointer after the push |

## Verification
The bound checker monitors properties on every clock. It checks that the strobes are mutually exclusive and match the cycle code, that every acknowledge run lasts 5 or 7 T-states, that done is a single pulse right after the sequence ends, that the reported stack pointer is two below the value seen at accept, that an NMI always targets 0x0066, and that an unsupported request stays off the bus. Other behaviours show up only in the bench's scenarios, where a reference model compares every T-state. These are the exact address and data of each push and table read, the pointer wrap from 0xFFFF to 0x0000 with an odd ack byte, mode 1 ignoring the device byte, the mode input being ignored for NMI, and stray accept pulses during a sequence.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_NMIACK = 3'd1,
    CYC_INTACK = 3'd2,
    CYC_MWR    = 3'd3,
    CYC_MRD    = 3'd4
  } cyc_e;

  typedef enum logic [1:0] {
    K_NMI = 2'd0,
    K_IM1 = 2'd1,
    K_IM2 = 2'd2
  } kind_e;

  // cycle type of machine cycle idx for a response kind
  function automatic cyc_e mc_type(kind_e k, logic [2:0] idx);
    if (idx == 3'd0) return (k == K_NMI) ? CYC_NMIACK : CYC_INTACK;
    else if (idx < 3'd3) return CYC_MWR;
    else return CYC_MRD;
  endfunction

  function automatic logic [2:0] mc_total(kind_e k);
    return (k == K_IM2) ? 3'd5 : 3'd3;
  endfunction

  // push slot: idx 1 -> SP-1, idx 2 -> SP-2
  function automatic logic [AW-1:0] push_addr(logic [AW-1:0] sp, logic [2:0] idx);
    return sp - AW'(idx);
  endfunction

  // table slot: idx 3 -> pointer, idx 4 -> pointer+1
  function automatic logic [AW-1:0] ptr_addr(logic [DW-1:0] pg, logic [DW-1:0] v,
                                             logic [2:0] idx);
    return {pg, v} + AW'(idx - 3'd3);
  endfunction

  function automatic logic [AW-1:0] sp_after(logic [AW-1:0] sp);
    return sp - AW'(2);
  endfunction
endpackage

// File: rtl/intr_tcount.sv
module intr_tcount #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] t_q;

  assign last = run && (t_q == len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          t_q <= '0;
    else if (!run || last) t_q <= '0;
    else                 t_q <= t_q + CW'(1);
  end
endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] ireg_i,
  input  logic [DW-1:0] data_i,
  input  cyc_e          cyc,
  input  logic [2:0]    mc,
  input  logic          mc_last,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dout_o,
  output logic [DW-1:0] lo_o,
  output logic [AW-1:0] sp_o
);
  logic [AW-1:0] pc_q, sp_q;
  logic [DW-1:0] pg_q, vec_q, lo_q;
  logic          ack_end, rd0_end;

  assign ack_end = mc_last && (cyc == CYC_NMIACK || cyc == CYC_INTACK);
  assign rd0_end = mc_last && (cyc == CYC_MRD) && (mc == 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= '0;
      pg_q  <= '0;
      vec_q <= '0;
      lo_q  <= '0;
    end else begin
      if (load) begin
        pc_q <= pc_i;
        sp_q <= sp_i;
        pg_q <= ireg_i;
      end
      if (ack_end) vec_q <= data_i;
      if (rd0_end) lo_q  <= data_i;
    end
  end

  always_comb begin
    addr_o = '0;
    dout_o = '0;
    unique case (cyc)
      CYC_NMIACK, CYC_INTACK: addr_o = pc_q;
      CYC_MWR: begin
        addr_o = push_addr(sp_q, mc);
        dout_o = (mc == 3'd1) ? pc_q[AW-1:DW] : pc_q[DW-1:0];
      end
      CYC_MRD: addr_o = ptr_addr(pg_q, vec_q, mc);
      default: ;
    endcase
  end

  assign lo_o = lo_q;
  assign sp_o = sp_q;
endmodule

// File: rtl/intr_resp_seq.sv
module intr_resp_seq
  import intr_pkg::*;
#(
  parameter logic [15:0] NMI_VEC   = 16'h0066,
  parameter logic [15:0] IM1_VEC   = 16'h0038,
  parameter int          ACK_NMI_T = 5,
  parameter int          ACK_INT_T = 7,
  parameter int          MEM_T     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  logic        is_nmi_i,
  input  logic [1:0]  mode_i,
  input  logic [15:0] pc_i,
  input  logic [15:0] sp_i,
  input  logic [7:0]  ireg_i,
  input  logic [7:0]  data_i,
  output logic [15:0] addr_o,
  output logic [7:0]  dout_o,
  output logic        rd_o,
  output logic        wr_o,
  output logic        ack_o,
  output logic [2:0]  cyc_o,
  output logic        done_o,
  output logic        unsup_o,
  output logic [15:0] pc_new_o,
  output logic [15:0] sp_new_o
);
  localparam int MAXA = (ACK_INT_T > ACK_NMI_T) ? ACK_INT_T : ACK_NMI_T;
  localparam int MAXT = (MAXA > MEM_T) ? MAXA : MEM_T;
  localparam int CW   = $clog2(MAXT + 1);

  logic          busy_q, done_q, unsup_q;
  kind_e         kind_q;
  logic [2:0]    mc_q;
  logic [AW-1:0] pc_new_q, sp_new_q, sp_cur, target;
  logic [DW-1:0] lo_byte;
  cyc_e          cyc;
  logic [CW-1:0] len;

  // named events for the checker
  logic accept_idle, accept_go, accept_bad, mc_last, seq_end;

  assign accept_idle = accept_i && !busy_q;
  assign accept_go   = accept_idle && (is_nmi_i || mode_i == 2'd1 || mode_i == 2'd2);
  assign accept_bad  = accept_idle && !accept_go;

  assign cyc = busy_q ? mc_type(kind_q, mc_q) : CYC_IDLE;

  always_comb begin
    unique case (cyc)
      CYC_NMIACK: len = CW'(ACK_NMI_T);
      CYC_INTACK: len = CW'(ACK_INT_T);
      default:    len = CW'(MEM_T);
    endcase
  end

  intr_tcount #(.CW(CW)) u_tcnt (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .len(len), .last(mc_last)
  );

  intr_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .load(accept_go),
    .pc_i(pc_i), .sp_i(sp_i), .ireg_i(ireg_i), .data_i(data_i),
    .cyc(cyc), .mc(mc_q), .mc_last(mc_last),
    .addr_o(addr_o), .dout_o(dout_o), .lo_o(lo_byte), .sp_o(sp_cur)
  );

  assign seq_end = mc_last && (mc_q == mc_total(kind_q) - 3'd1);

  always_comb begin
    unique case (kind_q)
      K_NMI:   target = NMI_VEC;
      K_IM1:   target = IM1_VEC;
      default: target = {data_i, lo_byte};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      unsup_q  <= 1'b0;
      kind_q   <= K_NMI;
      mc_q     <= '0;
      pc_new_q <= '0;
      sp_new_q <= '0;
    end else begin
      done_q  <= 1'b0;
      unsup_q <= 1'b0;
      if (accept_go) begin
        busy_q <= 1'b1;
        mc_q   <= '0;
        kind_q <= is_nmi_i ? K_NMI : ((mode_i == 2'd1) ? K_IM1 : K_IM2);
      end else if (accept_bad) begin
        unsup_q <= 1'b1;
      end else if (mc_last) begin
        if (seq_end) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          pc_new_q <= target;
          sp_new_q <= sp_after(sp_cur);
        end else begin
          mc_q <= mc_q + 3'd1;
        end
      end
    end
  end

  assign cyc_o    = cyc;
  assign ack_o    = (cyc == CYC_NMIACK) || (cyc == CYC_INTACK);
  assign rd_o     = (cyc == CYC_MRD);
  assign wr_o     = (cyc == CYC_MWR);
  assign done_o   = done_q;
  assign unsup_o  = unsup_q;
  assign pc_new_o = pc_new_q;
  assign sp_new_o = sp_new_q;
endmodule

// File: rtl/intr_resp_chk.sv
module intr_resp_chk #(
  parameter logic [15:0] NMI_VEC = 16'h0066
) (
  input logic        clk,
  input logic        rst_n,
  input logic        accept_i,
  input logic        is_nmi_i,
  input logic [15:0] sp_i,
  input logic [2:0]  cyc_o,
  input logic        ack_o,
  input logic        rd_o,
  input logic        wr_o,
  input logic        done_o,
  input logic        unsup_o,
  input logic [15:0] pc_new_o,
  input logic [15:0] sp_new_o,
  input logic        busy,
  input logic        seq_end
);
  logic [7:0]  ack_run;
  logic [15:0] sp_cap;
  logic        nmi_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_run <= '0;
      sp_cap  <= '0;
      nmi_cap <= 1'b0;
    end else begin
      ack_run <= ack_o ? ack_run + 8'd1 : 8'd0;
      if (accept_i && !busy) begin
        sp_cap  <= sp_i;
        nmi_cap <= is_nmi_i;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $countones({ack_o, rd_o, wr_o}) <= 1); // R6
  AST_ACK_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n) ack_o |-> (cyc_o == 3'd1 || cyc_o == 3'd2)); // R6
  AST_ACK_LEN: assert property (@(posedge clk) disable iff (!rst_n) (!ack_o && ack_run != 8'd0) |-> (ack_run == 8'd5 || ack_run == 8'd7)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) seq_end |=> (done_o && cyc_o == 3'd0)); // R7
  AST_SP_RESULT: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (sp_new_o == sp_cap - 16'd2)); // R3
  AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (done_o && nmi_cap) |-> (pc_new_o == NMI_VEC)); // R2
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) unsup_o |-> (cyc_o == 3'd0 && !done_o && !ack_o)); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && accept_i && !seq_end) |=> busy); // R8
endmodule

bind intr_resp_seq intr_resp_chk #(.NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .is_nmi_i(is_nmi_i), .sp_i(sp_i),
  .cyc_o(cyc_o), .ack_o(ack_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o),
  .unsup_o(unsup_o), .pc_new_o(pc_new_o), .sp_new_o(sp_new_o),
  .busy(busy_q), .seq_end(seq_end)
);

// File: tb/sim_intr_resp_seq.sv
module sim_intr_resp_seq;
  localparam int TCLK = 10;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        accept_i = 1'b0, is_nmi_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic [7:0]  ireg_i = '0, data_i = '0;
  logic [15:0] addr_o, pc_new_o, sp_new_o;
  logic [7:0]  dout_o;
  logic        rd_o, wr_o, ack_o, done_o, unsup_o;
  logic [2:0]  cyc_o;

  int n_tests = 0, n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  intr_resp_seq u0 (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .is_nmi_i(is_nmi_i), .mode_i(mode_i),
    .pc_i(pc_i), .sp_i(sp_i), .ireg_i(ireg_i), .data_i(data_i),
    .addr_o(addr_o), .dout_o(dout_o), .rd_o(rd_o), .wr_o(wr_o), .ack_o(ack_o),
    .cyc_o(cyc_o), .done_o(done_o), .unsup_o(unsup_o),
    .pc_new_o(pc_new_o), .sp_new_o(sp_new_o)
  );

  typedef struct packed {
    logic [2:0]  cyc;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic        ack, rd, wr;
    logic [7:0]  din;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic add_mc(input logic [2:0] c, input int n, input logic [15:0] a,
                        input logic [7:0] d, input logic [7:0] din);
    for (int k = 0; k < n; k++)
      q.push_back({c, a, d, (c == 3'd1 || c == 3'd2), c == 3'd4, c == 3'd3, din});
  endtask

  task automatic chk_idle(input string tag);
    chk({cyc_o, addr_o, dout_o, ack_o, rd_o, wr_o, done_o} == '0, tag,
        {1'b0, cyc_o, addr_o, dout_o, ack_o, rd_o, wr_o, done_o}, 32'h0);
  endtask

  // one full response; retrig >= 0 raises accept again at that T-state
  task automatic run_seq(input bit nmi, input logic [1:0] mode, input logic [15:0] pc,
                         input logic [15:0] sp, input logic [7:0] pg, input logic [7:0] vec,
                         input logic [7:0] lo, input logic [7:0] hi, input int retrig,
                         input string tag);
    logic [15:0] ptr, tgt;
    bit im2;
    exp_t e;
    int idx;
    im2 = !nmi && (mode == 2'd2);
    ptr = {pg, vec};
    q.delete();
    if (nmi) add_mc(3'd1, 5, pc, 8'h00, vec);
    else     add_mc(3'd2, 7, pc, 8'h00, vec);
    add_mc(3'd3, 3, sp - 16'd1, pc[15:8], 8'h00);
    add_mc(3'd3, 3, sp - 16'd2, pc[7:0], 8'h00);
    if (im2) begin
      add_mc(3'd4, 3, ptr, 8'h00, lo);
      add_mc(3'd4, 3, ptr + 16'd1, 8'h00, hi);
    end
    tgt = nmi ? 16'h0066 : (im2 ? {hi, lo} : 16'h0038);
    is_nmi_i = nmi; mode_i = mode; pc_i = pc; sp_i = sp; ireg_i = pg;
    accept_i = 1'b1;
    idx = 0;
    while (q.size() > 0) begin
      @(negedge clk);
      accept_i = 1'b0;
      e = q.pop_front();
      chk({cyc_o, addr_o, dout_o} == {e.cyc, e.addr, e.dout},
          (e.cyc == 3'd3) ? "R3" : tag,
          {5'd0, cyc_o, addr_o, dout_o}, {5'd0, e.cyc, e.addr, e.dout});
      chk({ack_o, rd_o, wr_o} == {e.ack, e.rd, e.wr}, "R6",
          {29'd0, ack_o, rd_o, wr_o}, {29'd0, e.ack, e.rd, e.wr});
      chk(done_o == 1'b0, "R7", {31'd0, done_o}, 32'd0);
      data_i = e.din;
      if (idx == retrig) begin
        accept_i = 1'b1; is_nmi_i = ~nmi; mode_i = 2'd1;
        pc_i = ~pc; sp_i = ~sp; ireg_i = ~pg;
      end
      idx++;
    end
    @(negedge clk);
    accept_i = 1'b0; data_i = 8'h00;
    chk(done_o == 1'b1 && cyc_o == 3'd0, "R7", {30'd0, done_o, cyc_o == 3'd0}, 32'd3);
    chk(pc_new_o == tgt, tag, {16'd0, pc_new_o}, {16'd0, tgt});
    chk(sp_new_o == sp - 16'd2, "R3", {16'd0, sp_new_o}, {16'd0, sp - 16'd2});
    @(negedge clk);
    chk_idle((retrig >= 0) ? "R8" : "R1");
    chk(pc_new_o == tgt && sp_new_o == sp - 16'd2, "R7",
        {pc_new_o, sp_new_o}, {tgt, sp - 16'd2});
    @(negedge clk);
    chk_idle((retrig >= 0) ? "R8" : "R1");
  endtask

  task automatic run_unsup(input logic [1:0] mode);
    logic [15:0] pc_prev, sp_prev;
    pc_prev = pc_new_o; sp_prev = sp_new_o;
    is_nmi_i = 1'b0; mode_i = mode; pc_i = 16'h4321; sp_i = 16'h7000;
    accept_i = 1'b1;
    @(negedge clk);
    accept_i = 1'b0;
    chk(unsup_o == 1'b1, "R9", {31'd0, unsup_o}, 32'd1);
    chk_idle("R9");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(unsup_o == 1'b0, "R9", {31'd0, unsup_o}, 32'd0);
      chk_idle("R9");
    end
    chk(pc_new_o == pc_prev && sp_new_o == sp_prev, "R9",
        {pc_new_o, sp_new_o}, {pc_prev, sp_prev});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_idle("R1");
    chk(unsup_o == 1'b0 && pc_new_o == 16'h0 && sp_new_o == 16'h0, "R1",
        {15'd0, unsup_o, pc_new_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    run_seq(1'b1, 2'd1, 16'h1234, 16'h8000, 8'h00, 8'hEE, 8'h00, 8'h00, -1, "R2");
    run_seq(1'b1, 2'd0, 16'hBEEF, 16'h0100, 8'h00, 8'h11, 8'h00, 8'h00, -1, "R10");
    run_seq(1'b0, 2'd1, 16'hABCD, 16'h0001, 8'h00, 8'h5A, 8'h00, 8'h00, -1, "R4");
    run_seq(1'b0, 2'd1, 16'h0F0F, 16'h0000, 8'h00, 8'hC3, 8'h00, 8'h00, 3, "R4");
    run_seq(1'b0, 2'd2, 16'h5555, 16'hFFF0, 8'h12, 8'h35, 8'h78, 8'h9A, -1, "R5");
    run_seq(1'b0, 2'd2, 16'h00FF, 16'h2000, 8'hFF, 8'hFF, 8'hA1, 8'hB2, 10, "R5");
    run_seq(1'b1, 2'd2, 16'h7777, 16'h3000, 8'h00, 8'h00, 8'h00, 8'h00, 10, "R8");
    run_unsup(2'd0);
    run_unsup(2'd3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule